// File: doc/BRIEF.md
# IDE PIO Sector Transfer Sequencer

This block runs single-command, multi-sector programmed-I/O reads and writes against an IDE/ATA register file. It uses no interrupt line. A requester hands over one request: direction, drive, head, cylinder, starting sector and sector count. The sequencer then does the following:

- It polls the status register until the device is idle and ready.
- It programs the command-block registers and issues the read-with-retry or write-with-retry command.
- For each sector, it moves a fixed number of 16-bit words between the data port and a word FIFO.
- It finishes with a one-cycle `done` pulse.

The physical bus is abstracted as a register port. One access is outstanding at a time. The request is held until the device acknowledges it.

The controller is one state machine with these states: `S_IDLE`, `S_WAIT_RDY`, `S_SETUP`, `S_CMD`, `S_WAIT_DRQ`, `S_XFER`, `S_WAIT_END`, `S_GET_ERR` and `S_FINISH`. Its transitions are:

- `S_IDLE`→`S_WAIT_RDY` on an accepted request.
- `S_WAIT_RDY`→`S_SETUP` when a poll shows not-busy and ready.
- `S_SETUP`→`S_CMD` after the fifth parameter write.
- `S_CMD`→`S_WAIT_DRQ` once the command is written.
- `S_WAIT_DRQ`→`S_XFER` when a poll shows not-busy with data request.
- `S_XFER`→`S_WAIT_DRQ` at the end of a sector that is not the last.
- `S_XFER`→`S_WAIT_END` at the end of the last sector of a write.
- `S_XFER`→`S_FINISH` at the end of the last sector of a read.
- `S_WAIT_END`→`S_FINISH` when a poll shows not-busy.
- From any polling state, →`S_GET_ERR` when a not-busy poll shows error or write fault.
- From any polling state, →`S_FINISH` when the poll limit is reached.
- `S_GET_ERR`→`S_FINISH` once the error register is read.
- `S_FINISH`→`S_IDLE` always.

A sector count of zero is loaded as 256 sectors.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `err`, `timeout`, `reg_req`, `src_pop` and `snk_push` are 0.
- R2: After a request is accepted, the block reads the status register (address 7) repeatedly. It writes no register until a status value arrives with bit 7 (busy) at 0 and bit 6 (ready) at 1.
- R3: The block then writes the parameter registers in this order:
  - drive/head at address 6. The byte is bit7=1, bit6=0, bit5=1, bit4=drive, bits3..0=head.
  - sector count at address 2.
  - sector number at address 3.
  - cylinder low byte at address 4.
  - cylinder high byte at address 5.
- R4: Right after the parameter writes, the command is written to address 7. The value is 0x20 for a read and 0x30 for a write.
- R5: For every sector, the block polls status until busy=0 and bit 3 (data request)=1. It then makes exactly 256 data-port accesses at address 0. For a read, each word read goes to the sink. For a write, each word is popped from the source and written.
- R6: A data-port access is started only when the sink is not full (read) or the source is not empty (write).
- R7: For a write, after the last sector the block polls status until busy=0 before raising `done`.
- R8: On any status value with busy=0 and either bit 0 (error) or bit 5 (write fault) set, the block stops polling and reads address 1. It latches that byte on `err_code`, moves no more data, and raises `done` with `err`=1.
- R9: When the number of consecutive status polls in one wait phase that do not satisfy that wait reaches `poll_limit`, the block raises `done` with `timeout`=1 and `err`=0.
- R10: `done` is a one-cycle pulse. `err`, `timeout` and `err_code` hold their values until the next request is accepted. A request accepted after a failure starts with both flags at 0.
- R11: While `reg_req` is high and `reg_ack` is low, `reg_req`, `reg_addr` and `reg_we` stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (accepted when `req_ready`) |
| req_write | input | 1 | 1 = write sectors, 0 = read sectors |
| req_drive | input | 1 | Drive select |
| req_head | input | 4 | Head number |
| req_cyl | input | 16 | Cylinder |
| req_sector | input | 8 | Starting sector number |
| req_count | input | 8 | Sector count (0 means 256) |
| req_ready | output | 1 | Sequencer idle |
| poll_limit | input | TW | Unsatisfied-poll limit per wait phase |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 3 | Command-block register address |
| reg_wdata | output | 16 | Write data (low byte for 8-bit registers) |
| reg_rdata | input | 16 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access completes at this clock edge |
| src_empty | input | 1 | Write-data FIFO empty |
| src_data | input | 16 | Write-data FIFO head word |
| src_pop | output | 1 | Pop the write-data FIFO |
| snk_full | input | 1 | Read-data FIFO full |
| snk_push | output | 1 | Push `snk_data` into the read-data FIFO |
| snk_data | output | 16 | Word read from the data port |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Transfer ended on a device error or write fault |
| timeout | output | 1 | Transfer ended on the poll limit |
| err_code | output | 8 | Error register value captured on an error |

## Verification
A sequencer stuck in a wrong state shows up in the next register access. It would read the wrong address, write a parameter out of order or while the device is busy, or touch the data port before the data request appears. The device model reports each of these the cycle it happens. A wrong word counter or sector counter shows up at the end of a sector. The sink or source then sees more or fewer than 256 words per sector, or `done` arrives while the device still reports busy. A corrupted flag is visible at the `done` pulse and for as long as the block stays idle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_RDY,
        S_SETUP,
        S_CMD,
        S_WAIT_DRQ,
        S_XFER,
        S_WAIT_END,
        S_GET_ERR,
        S_FINISH
    } seq_state_t;

    typedef struct packed {
        logic        write;
        logic        drive;
        logic [3:0]  head;
        logic [15:0] cyl;
        logic [7:0]  sect;
        logic [7:0]  count;
    } seq_req_t;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_ERR  = 3'd1;
    localparam logic [2:0] A_SCNT = 3'd2;
    localparam logic [2:0] A_SNUM = 3'd3;
    localparam logic [2:0] A_CYLL = 3'd4;
    localparam logic [2:0] A_CYLH = 3'd5;
    localparam logic [2:0] A_DH   = 3'd6;
    localparam logic [2:0] A_STAT = 3'd7;

    localparam int B_BSY = 7;
    localparam int B_RDY = 6;
    localparam int B_DF  = 5;
    localparam int B_DRQ = 3;
    localparam int B_ERR = 0;

    localparam logic [7:0] OP_READ  = 8'h20;
    localparam logic [7:0] OP_WRITE = 8'h30;

    function automatic logic [7:0] make_dh(input logic drive, input logic [3:0] head);
        return {3'b101, drive, head};
    endfunction

endpackage

// File: rtl/ata_status_eval.sv
module ata_status_eval import ata_pio_pkg::*; (
    input  logic [7:0] status_i,
    input  logic       need_rdy_i,
    input  logic       need_drq_i,
    output logic       go_o,
    output logic       fault_o
);

    logic idle;

    always_comb begin
        idle    = !status_i[B_BSY];
        fault_o = idle && (status_i[B_ERR] || status_i[B_DF]);
        go_o    = idle && !fault_o
                  && (!need_rdy_i || status_i[B_RDY])
                  && (!need_drq_i || status_i[B_DRQ]);
    end

endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);

    logic [TW-1:0] cnt;
    logic [TW:0]   next_cnt;

    assign next_cnt = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    assign expire_o = tick_i && (next_cnt >= {1'b0, limit_i});

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= next_cnt[TW-1:0];
        end
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !clear_i |=> $stable(cnt));

endmodule

// File: rtl/ata_word_ctr.sv
module ata_word_ctr #(
    parameter int WORDS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic last_o
);

    localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

    logic [CW-1:0] cnt;

    assign last_o = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt <= '0;
        end else if (step_i) begin
            cnt <= last_o ? '0 : cnt + 1'b1;
        end
    end

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && last_o && !clear_i |=> cnt == '0);

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq import ata_pio_pkg::*; #(
    parameter int WORDS = 256,
    parameter int TW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_drive,
    input  logic [3:0]    req_head,
    input  logic [15:0]   req_cyl,
    input  logic [7:0]    req_sector,
    input  logic [7:0]    req_count,
    output logic          req_ready,
    input  logic [TW-1:0] poll_limit,
    output logic          reg_req,
    output logic          reg_we,
    output logic [2:0]    reg_addr,
    output logic [15:0]   reg_wdata,
    input  logic [15:0]   reg_rdata,
    input  logic          reg_ack,
    input  logic          src_empty,
    input  logic [15:0]   src_data,
    output logic          src_pop,
    input  logic          snk_full,
    output logic          snk_push,
    output logic [15:0]   snk_data,
    output logic          done,
    output logic          err,
    output logic          timeout,
    output logic [7:0]    err_code
);

    localparam logic [2:0] SETUP_LAST = 3'd4;

    seq_state_t state, state_nx;
    seq_req_t   rq;
    logic [8:0] secs_left;
    logic [2:0] setup_idx;
    logic       acc_hold;
    logic       err_q, to_q;
    logic [7:0] code_q;

    logic poll_st, poll_go, poll_fault, poll_tick, poll_expire;
    logic word_last, xfer_ack, sector_end, last_sector;

    assign poll_st     = (state == S_WAIT_RDY) || (state == S_WAIT_DRQ) || (state == S_WAIT_END);
    assign xfer_ack    = (state == S_XFER) && reg_ack;
    assign sector_end  = xfer_ack && word_last;
    assign last_sector = (secs_left == 9'd1);
    assign poll_tick   = poll_st && reg_ack && !poll_go && !poll_fault;

    ata_status_eval u_eval (
        .status_i   (reg_rdata[7:0]),
        .need_rdy_i (state == S_WAIT_RDY),
        .need_drq_i (state == S_WAIT_DRQ),
        .go_o       (poll_go),
        .fault_o    (poll_fault)
    );

    ata_poll_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (!poll_st),
        .tick_i   (poll_tick),
        .limit_i  (poll_limit),
        .expire_o (poll_expire)
    );

    ata_word_ctr #(.WORDS(WORDS)) u_words (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (state != S_XFER),
        .step_i  (xfer_ack),
        .last_o  (word_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_WAIT_RDY;
            S_WAIT_RDY, S_WAIT_DRQ, S_WAIT_END: begin
                if (reg_ack) begin
                    if (poll_fault)       state_nx = S_GET_ERR;
                    else if (poll_go)     state_nx = (state == S_WAIT_RDY) ? S_SETUP :
                                                     (state == S_WAIT_DRQ) ? S_XFER : S_FINISH;
                    else if (poll_expire) state_nx = S_FINISH;
                end
            end
            S_SETUP:    if (reg_ack && setup_idx == SETUP_LAST) state_nx = S_CMD;
            S_CMD:      if (reg_ack) state_nx = S_WAIT_DRQ;
            S_XFER: begin
                if (sector_end) begin
                    if (!last_sector)  state_nx = S_WAIT_DRQ;
                    else if (rq.write) state_nx = S_WAIT_END;
                    else               state_nx = S_FINISH;
                end
            end
            S_GET_ERR:  if (reg_ack) state_nx = S_FINISH;
            S_FINISH:   state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // request, counters and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq        <= '0;
            secs_left <= '0;
            setup_idx <= '0;
            acc_hold  <= 1'b0;
            err_q     <= 1'b0;
            to_q      <= 1'b0;
            code_q    <= '0;
        end else begin
            acc_hold <= reg_req && !reg_ack;
            if (state == S_IDLE && req_valid) begin
                rq        <= '{write: req_write, drive: req_drive, head: req_head,
                               cyl: req_cyl, sect: req_sector, count: req_count};
                secs_left <= (req_count == 8'd0) ? 9'd256 : {1'b0, req_count};
                err_q     <= 1'b0;
                to_q      <= 1'b0;
                code_q    <= '0;
            end
            if (state != S_SETUP)  setup_idx <= '0;
            else if (reg_ack)      setup_idx <= setup_idx + 3'd1;
            if (sector_end)        secs_left <= secs_left - 9'd1;
            if (poll_st && reg_ack && !poll_fault && !poll_go && poll_expire) to_q <= 1'b1;
            if (state == S_GET_ERR && reg_ack) begin
                err_q  <= 1'b1;
                code_q <= reg_rdata[7:0];
            end
        end
    end

    // outputs
    always_comb begin
        reg_req   = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = A_STAT;
        reg_wdata = '0;
        src_pop   = 1'b0;
        snk_push  = 1'b0;
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE:     req_ready = 1'b1;
            S_WAIT_RDY, S_WAIT_DRQ, S_WAIT_END: begin
                reg_req  = 1'b1;
                reg_addr = A_STAT;
            end
            S_SETUP: begin
                reg_req = 1'b1;
                reg_we  = 1'b1;
                case (setup_idx)
                    3'd1:    begin reg_addr = A_SCNT; reg_wdata = {8'h00, rq.count};     end
                    3'd2:    begin reg_addr = A_SNUM; reg_wdata = {8'h00, rq.sect};      end
                    3'd3:    begin reg_addr = A_CYLL; reg_wdata = {8'h00, rq.cyl[7:0]};  end
                    3'd4:    begin reg_addr = A_CYLH; reg_wdata = {8'h00, rq.cyl[15:8]}; end
                    default: begin reg_addr = A_DH;   reg_wdata = {8'h00, make_dh(rq.drive, rq.head)}; end
                endcase
            end
            S_CMD: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = A_STAT;
                reg_wdata = {8'h00, rq.write ? OP_WRITE : OP_READ};
            end
            S_XFER: begin
                reg_addr  = A_DATA;
                reg_we    = rq.write;
                reg_wdata = src_data;
                reg_req   = acc_hold || (rq.write ? !src_empty : !snk_full);
                src_pop   = rq.write && reg_ack;
                snk_push  = !rq.write && reg_ack;
            end
            S_GET_ERR: begin
                reg_req  = 1'b1;
                reg_addr = A_ERR;
            end
            S_FINISH:   done = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    assign snk_data = reg_rdata;
    assign err      = err_q;
    assign timeout  = to_q;
    assign err_code = code_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we));

    // R5
    push_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snk_push |-> reg_ack && !reg_we && reg_addr == A_DATA);

    // R5
    pop_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> reg_ack && reg_we && reg_addr == A_DATA);

    // R4
    cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_we && reg_addr == A_STAT |->
        reg_wdata[7:0] == OP_READ || reg_wdata[7:0] == OP_WRITE);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && timeout));

    // R8
    err_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(reg_ack && !reg_we && reg_addr == A_ERR));

endmodule

// File: tb/ata_pio_seq_bench.sv
module ata_pio_seq_bench;

    localparam int TW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_write, req_drive, req_ready;
    logic [3:0]    req_head;
    logic [15:0]   req_cyl;
    logic [7:0]    req_sector, req_count;
    logic [TW-1:0] poll_limit;
    logic          reg_req, reg_we, reg_ack;
    logic [2:0]    reg_addr;
    logic [15:0]   reg_wdata, reg_rdata;
    logic          src_empty, src_pop, snk_full, snk_push;
    logic [15:0]   src_data, snk_data;
    logic          done, err, timeout;
    logic [7:0]    err_code;

    ata_pio_seq #(.WORDS(256), .TW(TW)) u_ata_pio_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_drive(req_drive),
        .req_head(req_head), .req_cyl(req_cyl), .req_sector(req_sector),
        .req_count(req_count), .req_ready(req_ready), .poll_limit(poll_limit),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .src_empty(src_empty), .src_data(src_data), .src_pop(src_pop),
        .snk_full(snk_full), .snk_push(snk_push), .snk_data(snk_data),
        .done(done), .err(err), .timeout(timeout), .err_code(err_code)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [15:0] pat(input int s, input int w);
        return {8'(s) ^ 8'h5A, 8'(w)};
    endfunction

    // ---------------- device model ----------------
    int busy_n, m_count, sec_left_m, sec_idx, wcnt, end_busy, end_polls;
    bit drq, hang, err_inj, df_inj, err_flag, df_flag, cmd_wr, in_end;
    logic [7:0] errreg_val;
    logic [2:0] wl_addr [0:15];
    logic [7:0] wl_data [0:15];
    int wl_n, stat_reads, stat_first, data_rd, data_wr, wr_bad, viol_busy, viol_drq;
    logic ack_q;
    logic [15:0] rdata_q;
    int lat;

    assign reg_ack   = ack_q;
    assign reg_rdata = rdata_q;

    function automatic logic [15:0] rd_val(input logic [2:0] a);
        if (a == 3'd7) begin
            if (hang || busy_n > 0) return 16'h0080;
            return {8'h00, 1'b0, 1'b1, df_flag, 1'b0, drq, 2'b00, err_flag};
        end
        if (a == 3'd1) return {8'h00, errreg_val};
        if (a == 3'd0) return pat(sec_idx, wcnt);
        return 16'h0000;
    endfunction

    task automatic advance();
        wcnt++;
        if (wcnt == 256) begin
            wcnt = 0;
            sec_idx++;
            sec_left_m--;
            if (sec_left_m == 0) begin
                drq = 0;
                if (cmd_wr) begin
                    end_busy  = $urandom_range(1, 3);
                    busy_n    = end_busy;
                    in_end    = 1;
                    end_polls = 0;
                end
                if (df_inj) df_flag = 1;
            end else begin
                busy_n = $urandom_range(0, 4);
            end
        end
    endtask

    task automatic complete();
        if (reg_we) begin
            if (reg_addr == 3'd0) begin
                if (!drq || busy_n > 0) viol_drq++;
                if (reg_wdata != pat(sec_idx, wcnt)) wr_bad++;
                data_wr++;
                advance();
            end else begin
                if (busy_n > 0 || hang) viol_busy++;
                if (wl_n < 16) begin
                    wl_addr[wl_n] = reg_addr;
                    wl_data[wl_n] = reg_wdata[7:0];
                end
                if (wl_n == 0) stat_first = stat_reads;
                wl_n++;
                if (reg_addr == 3'd2) m_count = (reg_wdata[7:0] == 0) ? 256 : int'(reg_wdata[7:0]);
                if (reg_addr == 3'd7) begin
                    cmd_wr     = (reg_wdata[7:0] == 8'h30);
                    sec_left_m = m_count;
                    sec_idx    = 0;
                    wcnt       = 0;
                    busy_n     = $urandom_range(0, 4);
                    if (err_inj) begin err_flag = 1; drq = 0; end
                    else drq = 1;
                end
            end
        end else begin
            if (reg_addr == 3'd7) begin
                stat_reads++;
                if (in_end) end_polls++;
                if (busy_n > 0) busy_n--;
            end else if (reg_addr == 3'd0) begin
                if (!drq || busy_n > 0) viol_drq++;
                data_rd++;
                advance();
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            lat = 0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
            complete();
        end else if (reg_req) begin
            if (lat > 0) lat--;
            else begin
                ack_q   <= 1'b1;
                rdata_q <= rd_val(reg_addr);
                lat = $urandom_range(0, 2);
            end
        end
    end

    // ---------------- FIFOs and monitors ----------------
    bit thr;
    int src_n, snk_n, snk_bad, viol_flow, viol_hold, viol_pulse;
    bit hold_prev, done_prev;
    logic [2:0] addr_prev;
    logic we_prev;

    assign src_data = pat(src_n / 256, src_n % 256);

    always @(negedge clk) begin
        src_empty <= thr ? ($urandom_range(0, 3) == 0) : 1'b0;
        snk_full  <= thr ? ($urandom_range(0, 3) == 0) : 1'b0;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (src_pop) src_n++;
            if (snk_push) begin
                if (snk_data != pat(snk_n / 256, snk_n % 256)) snk_bad++;
                snk_n++;
            end
            if (reg_req && reg_addr == 3'd0 && !hold_prev) begin
                if (!reg_we && snk_full) viol_flow++;
                if (reg_we && src_empty) viol_flow++;
            end
            if (hold_prev && (!reg_req || reg_addr != addr_prev || reg_we != we_prev)) viol_hold++;
            if (done && done_prev) viol_pulse++;
            hold_prev = reg_req && !reg_ack;
            addr_prev = reg_addr;
            we_prev   = reg_we;
            done_prev = done;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        busy_n = 3; drq = 0; hang = 0; err_inj = 0; df_inj = 0;
        err_flag = 0; df_flag = 0; in_end = 0; end_polls = 0; end_busy = 0;
        errreg_val = 8'h04; wl_n = 0; stat_reads = 0; stat_first = -1;
        data_rd = 0; data_wr = 0; wr_bad = 0; viol_busy = 0; viol_drq = 0;
        src_n = 0; snk_n = 0; snk_bad = 0; m_count = 1;
    endtask

    task automatic run(input bit wr, input bit drv, input logic [3:0] hd,
                       input logic [15:0] cyl, input logic [7:0] sn,
                       input logic [7:0] cnt, input logic [TW-1:0] lim,
                       output bit got);
        @(negedge clk);
        req_write = wr; req_drive = drv; req_head = hd; req_cyl = cyl;
        req_sector = sn; req_count = cnt; poll_limit = lim; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0;
        for (int i = 0; i < 30000; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic chk_setup(input string tag, input logic [7:0] dh, input logic [7:0] cnt,
                             input logic [7:0] sn, input logic [15:0] cyl, input logic [7:0] op);
        logic [2:0] ea [0:5];
        logic [7:0] ed [0:5];
        ea = '{3'd6, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7};
        ed = '{dh, cnt, sn, cyl[7:0], cyl[15:8], op};
        chk(wl_n == 6, {tag, " register write count"}, wl_n, 6);
        for (int k = 0; k < 6; k++) begin
            chk(wl_addr[k] == ea[k], {tag, " write order address"}, int'(wl_addr[k]), int'(ea[k]));
            chk(wl_data[k] == ed[k], {tag, " write value"}, int'(wl_data[k]), int'(ed[k]));
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(done == 1'b0 && err == 1'b0 && timeout == 1'b0, "R1 result flags", int'({done, err, timeout}), 0);
        chk(reg_req == 1'b0 && src_pop == 1'b0 && snk_push == 1'b0, "R1 bus idle",
            int'({reg_req, src_pop, snk_push}), 0);
    endtask

    task automatic t_read_one();
        bit got;
        model_reset(); thr = 0;
        run(0, 0, 4'h5, 16'h1234, 8'h07, 8'h01, 16'd1000, got);
        chk(got, "R5 read one done", int'(got), 1);
        chk(stat_first == 4, "R2 polls before first write", stat_first, 4);
        chk(viol_busy == 0, "R2 writes while busy", viol_busy, 0);
        chk_setup("R3 R4 read one", 8'hA5, 8'h01, 8'h07, 16'h1234, 8'h20);
        chk(snk_n == 256 && data_rd == 256, "R5 words read", snk_n, 256);
        chk(snk_bad == 0, "R5 read data", snk_bad, 0);
        chk(viol_drq == 0, "R5 data without request", viol_drq, 0);
        chk(err == 0 && timeout == 0, "R10 clean flags", int'({err, timeout}), 0);
    endtask

    task automatic t_read_multi();
        bit got;
        model_reset(); thr = 1;
        run(0, 1, 4'hF, 16'hBEEF, 8'h21, 8'h03, 16'd1000, got);
        thr = 0;
        chk(got, "R5 read three done", int'(got), 1);
        chk_setup("R3 R4 read three", 8'hBF, 8'h03, 8'h21, 16'hBEEF, 8'h20);
        chk(snk_n == 768 && data_rd == 768, "R5 words read three", snk_n, 768);
        chk(snk_bad == 0 && viol_drq == 0, "R5 read three data", snk_bad + viol_drq, 0);
        chk(viol_flow == 0, "R6 start with sink full", viol_flow, 0);
    endtask

    task automatic t_write_two();
        bit got;
        model_reset(); thr = 1;
        run(1, 0, 4'h2, 16'h0300, 8'h01, 8'h02, 16'd1000, got);
        thr = 0;
        chk(got, "R7 write done", int'(got), 1);
        chk_setup("R3 R4 write two", 8'hA2, 8'h02, 8'h01, 16'h0300, 8'h30);
        chk(src_n == 512 && data_wr == 512, "R5 words written", data_wr, 512);
        chk(wr_bad == 0 && viol_drq == 0, "R5 write data", wr_bad + viol_drq, 0);
        chk(viol_flow == 0, "R6 start with source empty", viol_flow, 0);
        chk(busy_n == 0, "R7 done while busy", busy_n, 0);
        chk(end_polls == end_busy + 1, "R7 final polls", end_polls, end_busy + 1);
    endtask

    task automatic t_err_cmd();
        bit got;
        model_reset(); err_inj = 1; errreg_val = 8'h04;
        run(0, 0, 4'h1, 16'h0010, 8'h01, 8'h01, 16'd1000, got);
        chk(got && err == 1'b1, "R8 error flag", int'(err), 1);
        chk(err_code == 8'h04, "R8 error code", int'(err_code), 4);
        chk(timeout == 1'b0, "R8 no timeout", int'(timeout), 0);
        chk(data_rd == 0 && snk_n == 0, "R8 no data moved", data_rd, 0);
        repeat (5) @(negedge clk);
        chk(err == 1'b1 && err_code == 8'h04 && req_ready == 1'b1, "R10 flags held", int'(err), 1);
    endtask

    task automatic t_df_end();
        bit got;
        model_reset(); df_inj = 1; errreg_val = 8'h10;
        run(1, 1, 4'h0, 16'h0001, 8'h09, 8'h01, 16'd1000, got);
        chk(got && err == 1'b1, "R8 fault flag", int'(err), 1);
        chk(err_code == 8'h10, "R8 fault code", int'(err_code), 16);
        chk(data_wr == 256, "R8 words before fault", data_wr, 256);
    endtask

    task automatic t_timeout();
        bit got;
        model_reset(); hang = 1;
        run(0, 0, 4'h3, 16'h0002, 8'h01, 8'h01, 16'd20, got);
        chk(got && timeout == 1'b1, "R9 timeout flag", int'(timeout), 1);
        chk(err == 1'b0, "R9 no error", int'(err), 0);
        chk(stat_reads == 20, "R9 polls at limit", stat_reads, 20);
        chk(wl_n == 0, "R9 no register writes", wl_n, 0);
        repeat (4) @(negedge clk);
        chk(timeout == 1'b1, "R10 timeout held", int'(timeout), 1);
    endtask

    task automatic t_recover();
        bit got;
        model_reset();
        run(0, 0, 4'h6, 16'h0040, 8'h02, 8'h01, 16'd1000, got);
        chk(got && err == 1'b0 && timeout == 1'b0, "R10 flags cleared", int'({err, timeout}), 0);
        chk(snk_n == 256, "R5 recover words", snk_n, 256);
        chk(viol_pulse == 0, "R10 done width", viol_pulse, 0);
        chk(viol_hold == 0, "R11 request hold", viol_hold, 0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_drive = 1'b0;
        req_head = '0; req_cyl = '0; req_sector = '0; req_count = '0;
        poll_limit = '0; thr = 0; viol_flow = 0; viol_hold = 0; viol_pulse = 0;
        hold_prev = 0; done_prev = 0; addr_prev = '0; we_prev = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_one();
        t_read_multi();
        t_write_two();
        t_err_cmd();
        t_df_end();
        t_timeout();
        t_recover();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule